// File: doc/BRIEF.md
# SPI FIFO Status, Interrupt and DMA Request Unit

This block sits between the register bus of an SPI controller and its serial engine. It holds the transmit and receive word queues, keeps a level count for each, and turns those levels and the error events on them into a status word, five interrupt sources with individual masks, one combined interrupt line and two DMA request lines. Software pushes transmit words and pops receive words through two bus addresses. The engine drains the transmit queue and fills the receive queue through simple one-cycle strobes. Serial shifting and the bus protocol live outside this block.

A small run-control machine has three states. ST_OFF is the reset state, where configuration is open and the engine strobes are ignored. The transition ST_OFF to ST_ON is taken when 1 is written to the enable register. ST_ON to ST_FLUSH is taken when 0 is written to it. ST_FLUSH to ST_OFF is taken unconditionally after one cycle, and both queues are emptied on that edge. Interrupt thresholds can only be changed in ST_OFF. DMA watermarks are separate registers and may be changed at any time.

Register addresses (4-bit `bus_addr`): 0 enable, 1 transmit threshold, 2 receive threshold, 3 transmit level, 4 receive level, 5 status, 6 mask, 7 masked status, 8 raw status, 9 clear, 10 DMA enable, 11 transmit watermark, 12 receive watermark, 13 transmit data (write pushes), 14 receive data (read with `bus_re` pops). Reads are combinational from `bus_addr`. A write takes effect at the clock edge where `bus_we` is high.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset both levels read 0, the status word (address 5) reads 0x0C, raw status (address 8) reads 0x01, and `irq_o`, `dma_tx_req` and `dma_rx_req` are low.
- R2: Words pushed at address 13 leave on `eng_tx_data` in push order, one per `eng_tx_pop`. Words entered with `eng_rx_push` are returned in order by reads of address 14 with `bus_re` high. Addresses 3 and 4 report the current transmit and receive levels.
- R3: A push at address 13 while the transmit queue holds DEPTH words is dropped, the level stays at DEPTH, and raw bit 1 (transmit overflow) is set and stays set until cleared.
- R4: A pop of an empty receive queue returns 0 and sets raw bit 2 (receive underflow), which stays set until cleared.
- R5: An `eng_rx_push` while the receive queue is full is dropped and sets raw bit 3 (receive overflow), which stays set until cleared.
- R6: Status bit 0 is `eng_busy_i`, bit 1 is transmit full, bit 2 is transmit empty, bit 3 is receive empty and bit 4 is receive full.
- R7: Raw bit 0 is high while the transmit level is at or below the transmit threshold. Raw bit 4 is high while the receive level is greater than the receive threshold.
- R8: Writing the clear register (address 9) with bit 0 set clears all three sticky flags. Bit 1 clears receive underflow, bit 2 clears receive overflow and bit 3 clears transmit overflow. A new event in the same cycle wins over a clear.
- R9: Address 7 reads raw status ANDed with the mask (address 6), and `irq_o` is high exactly when that result is nonzero.
- R10: Threshold registers take a write only in ST_OFF and only when the written value is below DEPTH. Otherwise they keep their value.
- R11: DMA enable bit 0 enables the receive request and bit 1 enables the transmit request. `dma_tx_req` is high while enabled and the transmit level is at or below the transmit watermark. `dma_rx_req` is high while enabled and the receive level is above the receive watermark.
- R12: Writing 1 at address 0 enters ST_ON, and address 0 then reads 1. Engine strobes have effect only in ST_ON. Writing 0 passes through ST_FLUSH for one cycle, which leaves both queues empty in ST_OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops at address 14) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from address |
| eng_busy_i | input | 1 | Engine busy, reflected in status bit 0 |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_tx_data | output | DW | Head transmit word |
| eng_tx_empty | output | 1 | Transmit queue empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DW | Received word |
| eng_rx_full | output | 1 | Receive queue full |
| irq_o | output | 1 | Combined masked interrupt |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The hardest situations to reach are a clear and a fresh error landing close together, and the lock on threshold writes. Both depend on the run state and on the queue levels at the same moment. The stimulus first walks the run-control machine through every transition with directed writes and forces every overflow and underflow at exact queue boundaries. A seeded random mix of pushes, pops, engine strobes and clears then moves the levels up and down across the thresholds and both full and empty edges. A bench model predicts every level, sticky flag and data word in that phase.

// File: rtl/sfu_pkg.sv
`timescale 1ns/1ps
package sfu_pkg;
    typedef enum logic [1:0] {ST_OFF, ST_ON, ST_FLUSH} run_state_e;

    localparam int NSRC = 5;
    localparam int AW   = 4;

    localparam logic [AW-1:0] A_ENABLE = 4'd0;
    localparam logic [AW-1:0] A_TXTHR  = 4'd1;
    localparam logic [AW-1:0] A_RXTHR  = 4'd2;
    localparam logic [AW-1:0] A_TXLVL  = 4'd3;
    localparam logic [AW-1:0] A_RXLVL  = 4'd4;
    localparam logic [AW-1:0] A_STATUS = 4'd5;
    localparam logic [AW-1:0] A_MASK   = 4'd6;
    localparam logic [AW-1:0] A_MASKED = 4'd7;
    localparam logic [AW-1:0] A_RAW    = 4'd8;
    localparam logic [AW-1:0] A_CLEAR  = 4'd9;
    localparam logic [AW-1:0] A_DMAEN  = 4'd10;
    localparam logic [AW-1:0] A_TXWM   = 4'd11;
    localparam logic [AW-1:0] A_RXWM   = 4'd12;
    localparam logic [AW-1:0] A_TXDATA = 4'd13;
    localparam logic [AW-1:0] A_RXDATA = 4'd14;
endpackage

// File: rtl/sfu_fifo.sv
`timescale 1ns/1ps
module sfu_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [DW-1:0]                din,
    input  logic                         pop,
    output logic [DW-1:0]                dout,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty,
    output logic                         ovf_ev,
    output logic                         unf_ev
);
    localparam int PW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH-1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign ovf_ev  = push && full && !flush;
    assign unf_ev  = pop && empty && !flush;
    assign dout    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      level <= level + 1'b1;
            else if (pop_ok && !push_ok) level <= level - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wr_ptr] <= din;
    end

    // R2: the level never exceeds the queue depth
    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    // R3: a push into a full queue without a pop leaves it full
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> full);
    // R12: a flush leaves the queue empty
    p_flush_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/sfu_irq_core.sv
`timescale 1ns/1ps
module sfu_irq_core
    import sfu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_low,
    input  logic            rx_high,
    input  logic            ev_tx_ovf,
    input  logic            ev_rx_unf,
    input  logic            ev_rx_ovf,
    input  logic            clr_we,
    input  logic [3:0]      clr_bits,
    input  logic [NSRC-1:0] mask,
    output logic [NSRC-1:0] raw,
    output logic [NSRC-1:0] masked,
    output logic            irq
);
    logic tx_ovf_q, rx_unf_q, rx_ovf_q;
    logic clr_txo, clr_rxu, clr_rxo;

    assign clr_txo = clr_we && (clr_bits[0] || clr_bits[3]);
    assign clr_rxu = clr_we && (clr_bits[0] || clr_bits[1]);
    assign clr_rxo = clr_we && (clr_bits[0] || clr_bits[2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_ovf_q <= 1'b0;
            rx_unf_q <= 1'b0;
            rx_ovf_q <= 1'b0;
        end else begin
            if (ev_tx_ovf)    tx_ovf_q <= 1'b1;
            else if (clr_txo) tx_ovf_q <= 1'b0;
            if (ev_rx_unf)    rx_unf_q <= 1'b1;
            else if (clr_rxu) rx_unf_q <= 1'b0;
            if (ev_rx_ovf)    rx_ovf_q <= 1'b1;
            else if (clr_rxo) rx_ovf_q <= 1'b0;
        end
    end

    assign raw    = {rx_high, rx_ovf_q, rx_unf_q, tx_ovf_q, tx_low};
    assign masked = raw & mask;
    assign irq    = |masked;

    // R3: a transmit overflow event is recorded
    p_txovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_ovf |=> raw[1]);
    // R4: a receive underflow event is recorded
    p_rxunf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_unf |=> raw[2]);
    // R5: a receive overflow flag holds until a clear
    p_rxovf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[3] && !clr_rxo) |=> raw[3]);
    // R8: clearing without a new event drops the transmit overflow flag
    p_clear_txovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_bits[3] && !ev_tx_ovf) |=> !raw[1]);
endmodule

// File: rtl/spi_fifo_irq_unit.sv
`timescale 1ns/1ps
module spi_fifo_irq_unit
    import sfu_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic [3:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          eng_busy_i,
    input  logic          eng_tx_pop,
    output logic [DW-1:0] eng_tx_data,
    output logic          eng_tx_empty,
    input  logic          eng_rx_push,
    input  logic [DW-1:0] eng_rx_data,
    output logic          eng_rx_full,
    output logic          irq_o,
    output logic          dma_tx_req,
    output logic          dma_rx_req
);
    localparam int LW = $clog2(DEPTH+1);

    run_state_e state_q, state_d;
    logic run, flush, cfg_open;

    logic [LW-1:0] tx_thr_q, rx_thr_q, tx_wm_q, rx_wm_q;
    logic [NSRC-1:0] mask_q, raw, masked;
    logic [1:0] dma_en_q;

    logic [LW-1:0] tx_level, rx_level;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_ovf_ev, tx_unf_ev, rx_ovf_ev, rx_unf_ev;
    logic [DW-1:0] rx_head;
    logic [4:0] status_w;

    logic wr_en, wr_any, val_ok;
    assign wr_en  = bus_we && (bus_addr == A_ENABLE);
    assign wr_any = bus_we;
    assign val_ok = (bus_wdata < DW'(DEPTH));

    // run-control state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (wr_en && bus_wdata[0])  state_d = ST_ON;
            ST_ON:    if (wr_en && !bus_wdata[0]) state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    // run-control outputs
    always_comb begin
        run      = 1'b0;
        flush    = 1'b0;
        cfg_open = 1'b0;
        unique case (state_q)
            ST_OFF:   cfg_open = 1'b1;
            ST_ON:    run      = 1'b1;
            ST_FLUSH: flush    = 1'b1;
            default:  cfg_open = 1'b0;
        endcase
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_thr_q <= '0;
            rx_thr_q <= '0;
            tx_wm_q  <= '0;
            rx_wm_q  <= '0;
            mask_q   <= '0;
            dma_en_q <= '0;
        end else if (wr_any) begin
            unique case (bus_addr)
                A_TXTHR: if (cfg_open && val_ok) tx_thr_q <= bus_wdata[LW-1:0];
                A_RXTHR: if (cfg_open && val_ok) rx_thr_q <= bus_wdata[LW-1:0];
                A_TXWM:  if (val_ok) tx_wm_q <= bus_wdata[LW-1:0];
                A_RXWM:  if (val_ok) rx_wm_q <= bus_wdata[LW-1:0];
                A_MASK:  mask_q   <= bus_wdata[NSRC-1:0];
                A_DMAEN: dma_en_q <= bus_wdata[1:0];
                default: ;
            endcase
        end
    end

    logic [1:0]    q_push, q_pop;
    logic [DW-1:0] q_din  [2];
    logic [DW-1:0] q_dout [2];
    logic [LW-1:0] q_lvl  [2];
    logic [1:0]    q_full, q_empty, q_ovf, q_unf;

    assign q_push[0] = bus_we && (bus_addr == A_TXDATA);
    assign q_din[0]  = bus_wdata;
    assign q_pop[0]  = eng_tx_pop && run;
    assign q_push[1] = eng_rx_push && run;
    assign q_din[1]  = eng_rx_data;
    assign q_pop[1]  = bus_re && (bus_addr == A_RXDATA);

    for (genvar g = 0; g < 2; g++) begin : g_q
        sfu_fifo #(.DW(DW), .DEPTH(DEPTH)) u_q (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .push(q_push[g]), .din(q_din[g]), .pop(q_pop[g]),
            .dout(q_dout[g]), .level(q_lvl[g]),
            .full(q_full[g]), .empty(q_empty[g]),
            .ovf_ev(q_ovf[g]), .unf_ev(q_unf[g])
        );
    end

    assign eng_tx_data = q_dout[0];
    assign tx_level    = q_lvl[0];
    assign tx_full     = q_full[0];
    assign tx_empty    = q_empty[0];
    assign tx_ovf_ev   = q_ovf[0];
    assign tx_unf_ev   = q_unf[0];
    assign rx_head     = q_dout[1];
    assign rx_level    = q_lvl[1];
    assign rx_full     = q_full[1];
    assign rx_empty    = q_empty[1];
    assign rx_ovf_ev   = q_ovf[1];
    assign rx_unf_ev   = q_unf[1];

    assign eng_tx_empty = tx_empty;
    assign eng_rx_full  = rx_full;

    sfu_irq_core u_irq (
        .clk(clk), .rst_n(rst_n),
        .tx_low(tx_level <= tx_thr_q),
        .rx_high(rx_level > rx_thr_q),
        .ev_tx_ovf(tx_ovf_ev), .ev_rx_unf(rx_unf_ev), .ev_rx_ovf(rx_ovf_ev),
        .clr_we(bus_we && (bus_addr == A_CLEAR)),
        .clr_bits(bus_wdata[3:0]),
        .mask(mask_q), .raw(raw), .masked(masked), .irq(irq_o)
    );

    assign dma_tx_req = dma_en_q[1] && (tx_level <= tx_wm_q);
    assign dma_rx_req = dma_en_q[0] && (rx_level > rx_wm_q);

    assign status_w = {rx_full, rx_empty, tx_empty, tx_full, eng_busy_i};

    always_comb begin
        unique case (bus_addr)
            A_ENABLE: bus_rdata = DW'(run);
            A_TXTHR:  bus_rdata = DW'(tx_thr_q);
            A_RXTHR:  bus_rdata = DW'(rx_thr_q);
            A_TXLVL:  bus_rdata = DW'(tx_level);
            A_RXLVL:  bus_rdata = DW'(rx_level);
            A_STATUS: bus_rdata = DW'(status_w);
            A_MASK:   bus_rdata = DW'(mask_q);
            A_MASKED: bus_rdata = DW'(masked);
            A_RAW:    bus_rdata = DW'(raw);
            A_DMAEN:  bus_rdata = DW'(dma_en_q);
            A_TXWM:   bus_rdata = DW'(tx_wm_q);
            A_RXWM:   bus_rdata = DW'(rx_wm_q);
            A_RXDATA: bus_rdata = rx_head;
            default:  bus_rdata = '0;
        endcase
    end

    // R10: thresholds cannot move outside ST_OFF
    p_thr_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF) |=> ($stable(tx_thr_q) && $stable(rx_thr_q)));
    // R12: the flush state lasts exactly one cycle and ends in ST_OFF
    p_flush_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> (state_q == ST_OFF));
    // R12: engine strobes outside ST_ON leave the transmit level alone
    p_idle_engine_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !q_push[0]) |=> $stable(tx_level));
    // R4: an underflowing pop returns zero on the bus
    p_unf_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop[1] && rx_empty) |-> (bus_rdata == '0));
endmodule

// File: tb/spi_fifo_irq_unit_test.sv
`timescale 1ns/1ps
module spi_fifo_irq_unit_test;
    localparam int DW = 16;
    localparam int DEPTH = 16;
    localparam logic [3:0] AEN=0, ATT=1, ART=2, ATL=3, ARL=4, AST=5, AMK=6,
        AMD=7, ARW=8, ACL=9, ADE=10, ATW=11, ARW_WM=12, ATD=13, ARD=14;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_we = 0, bus_re = 0;
    logic [3:0] bus_addr = 0;
    logic [DW-1:0] bus_wdata = 0, bus_rdata;
    logic eng_busy_i = 0, eng_tx_pop = 0, eng_rx_push = 0;
    logic [DW-1:0] eng_tx_data, eng_rx_data = 0;
    logic eng_tx_empty, eng_rx_full, irq_o, dma_tx_req, dma_rx_req;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spi_fifo_irq_unit #(.DW(DW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy_i(eng_busy_i), .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_tx_empty(eng_tx_empty), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_rx_full(eng_rx_full), .irq_o(irq_o),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = DW'(d);
        @(negedge clk); bus_we = 0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk); bus_addr = a; #1 v = int'(bus_rdata);
    endtask

    task automatic rxpop(output int v);
        @(negedge clk); bus_addr = ARD; bus_re = 1; #1 v = int'(bus_rdata);
        @(negedge clk); bus_re = 0;
    endtask

    task automatic epop(output int v);
        @(negedge clk); eng_tx_pop = 1; #1 v = int'(eng_tx_data);
        @(negedge clk); eng_tx_pop = 0;
    endtask

    task automatic epush(input int d);
        @(negedge clk); eng_rx_push = 1; eng_rx_data = DW'(d);
        @(negedge clk); eng_rx_push = 0;
    endtask

    // expected raw word from levels and sticky flags
    function automatic int exp_raw(int txl, int rxl, int txthr, int rxthr,
                                   bit txo, bit rxu, bit rxo);
        return ((txl <= txthr) ? 1 : 0) | (txo << 1) | (rxu << 2) | (rxo << 3)
             | ((rxl > rxthr) ? 16 : 0);
    endfunction

    initial begin
        #(5ns * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v;
        int qtx[$];
        int qrx[$];
        bit stxo, srxu, srxo;
        int unsigned seed;
        seed = $urandom(32'h5eed);

        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(ATL, v); check("R1 tx level", v, 0);
        rd(ARL, v); check("R1 rx level", v, 0);
        rd(AST, v); check("R1 status", v, 'h0C);
        rd(ARW, v); check("R1 raw", v, 'h01);
        check("R1 irq/dma", {irq_o, dma_tx_req, dma_rx_req}, 0);

        // R10 thresholds in ST_OFF
        wr(ATT, 4); wr(ART, 2);
        rd(ATT, v); check("R10 tx thr", v, 4);
        rd(ART, v); check("R10 rx thr", v, 2);
        wr(ATT, 20); rd(ATT, v); check("R10 out of range ignored", v, 4);

        // R12 enable
        wr(AEN, 1); rd(AEN, v); check("R12 enabled", v, 1);
        wr(ATT, 7); rd(ATT, v); check("R10 locked while on", v, 4);

        // R3 transmit overflow, R6 status
        for (int i = 0; i < 17; i++) wr(ATD, 'h100 + i);
        rd(ATL, v); check("R3 tx level full", v, DEPTH);
        rd(ARW, v); check("R3 raw overflow", v, 'h02);
        rd(AST, v); check("R6 status tx full", v, 'h0A);
        eng_busy_i = 1;
        rd(AST, v); check("R6 status busy", v, 'h0B);
        eng_busy_i = 0;
        for (int i = 0; i < DEPTH; i++) begin
            epop(v); check("R2 tx order", v, 'h100 + i);
        end
        rd(ARW, v); check("R7 tx low + R3 sticky", v, 'h03);
        wr(ACL, 8); rd(ARW, v); check("R8 clear tx overflow", v, 'h01);

        // R4 underflow
        rxpop(v); check("R4 empty pop zero", v, 0);
        rd(ARW, v); check("R4 raw underflow", v, 'h05);
        wr(ACL, 2); rd(ARW, v); check("R8 clear underflow", v, 'h01);

        // R5 receive overflow
        for (int i = 0; i < 17; i++) epush('h200 + i);
        rd(ARL, v); check("R5 rx level full", v, DEPTH);
        rd(ARW, v); check("R5 raw overflow + R7 rx high", v, 'h19);
        rd(AST, v); check("R6 status rx full", v, 'h14);
        for (int i = 0; i < DEPTH; i++) begin
            rxpop(v); check("R2 rx order", v, 'h200 + i);
        end
        rd(ARW, v); check("R5 sticky after drain", v, 'h09);
        wr(ACL, 1); rd(ARW, v); check("R8 clear all", v, 'h01);

        // R9 mask and R7 threshold edge
        wr(AMK, 'h10);
        epush(1); epush(2); epush(3);
        rd(AMD, v); check("R9 masked", v, 'h10);
        check("R9 irq high", irq_o, 1);
        rxpop(v);
        rd(AMD, v); check("R7 rx at thr not above", v, 0);
        check("R9 irq low", irq_o, 0);

        // R11 DMA requests
        check("R11 disabled", {dma_tx_req, dma_rx_req}, 0);
        wr(ATW, 3); wr(ARW_WM, 1); wr(ADE, 3);
        #1 check("R11 both req", {dma_tx_req, dma_rx_req}, 3);
        wr(ADE, 1);
        #1 check("R11 rx only", {dma_tx_req, dma_rx_req}, 1);
        rxpop(v);
        #1 check("R11 rx at wm", {dma_tx_req, dma_rx_req}, 0);
        wr(ADE, 0);

        // R12 flush on disable, strobes ignored while off
        wr(ATD, 'h55); wr(ATD, 'h66);
        wr(AEN, 0); @(negedge clk);
        rd(ATL, v); check("R12 tx flushed", v, 0);
        rd(ARL, v); check("R12 rx flushed", v, 0);
        rd(AEN, v); check("R12 disabled", v, 0);
        wr(ATD, 'h77); epop(v); epush('h88);
        rd(ATL, v); check("R12 eng pop ignored", v, 1);
        rd(ARL, v); check("R12 eng push ignored", v, 0);
        wr(AEN, 1); epop(v); check("R2 held word", v, 'h77);
        wr(ACL, 1); wr(AMK, 'h1F);

        // random phase
        stxo = 0; srxu = 0; srxo = 0;
        for (int it = 0; it < 500; it++) begin
            int op = int'($urandom % 9);
            int d = int'($urandom & 16'hFFFF);
            if (op < 2) begin
                if (qtx.size() == DEPTH) stxo = 1; else qtx.push_back(d);
                wr(ATD, d);
            end else if (op < 4) begin
                epop(v);
                if (qtx.size() > 0) check("R2 random tx data", v, qtx.pop_front());
                else check("R2 random tx empty", v, 0);
            end else if (op < 6) begin
                if (qrx.size() == DEPTH) srxo = 1; else qrx.push_back(d);
                epush(d);
            end else if (op < 8) begin
                rxpop(v);
                if (qrx.size() > 0) check("R2 random rx data", v, qrx.pop_front());
                else begin srxu = 1; check("R4 random underflow zero", v, 0); end
            end else begin
                wr(ACL, 1); stxo = 0; srxu = 0; srxo = 0;
            end
            rd(ATL, v); check("R2 random tx level", v, qtx.size());
            rd(ARL, v); check("R2 random rx level", v, qrx.size());
            rd(ARW, v);
            check("R7 random raw", v, exp_raw(qtx.size(), qrx.size(), 4, 2, stxo, srxu, srxo));
            check("R9 random irq", irq_o, (v != 0) ? 1 : 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule